// File: doc/BRIEF.md
# Bulk IN Endpoint Transmit Controller

This block is the device-side transmit endpoint for bulk IN traffic. Software or a DMA engine pushes packet bytes in through a byte load port. Each finished packet waits in a small packet store until the packet engine sends it to the host. The store holds one packet, or two when two-packet buffering is switched on. While the endpoint is enabled for DMA and a packet slot is free, the block raises a DMA request. It keeps track of the DATA0/DATA1 sequence bit. It raises an endpoint interrupt when a packet is acknowledged, unless DMA mode suppresses that interrupt. It also raises the interrupt when a packet runs out of send attempts.

Three registers configure the block: a control/status register, a maximum-packet-size register and a buffer-configuration register. A packet is committed in one of two ways. If the loaded byte count reaches the maximum packet size, the packet commits by itself. Software commits a short packet explicitly. The packet engine rewinds to the head packet, reads its bytes one per request, and then reports either an ACK or a missing ACK for each attempt.

Top module: `bulk_in_ep_tx`

## Requirements
- R1: After reset the store is empty and the sequence bit is DATA0. The DMA request and the interrupt are low. The control/status register (address 0) reads 0, the max-packet register (address 1) reads MAX_PKT and the buffer-configuration register (address 2) reads 0.
- R2: With bit 4 of the buffer register clear, only one committed packet may wait. While it waits, bytes on the load port are ignored and control/status bit 0 (store full) reads 1.
- R3: With bit 4 of the buffer register set, two committed packets may wait. They are sent in commit order.
- R4: A packet commits by itself when its byte count reaches the max-packet value. A shorter packet, including an empty one, commits only when 1 is written to control/status bit 0. Control/status bit 1 reads 1 while any committed packet waits.
- R5: The registered DMA request is high exactly when control/status bit 12 (DMA enable) and bit 13 (transmit mode) are set and a packet slot is free.
- R6: An ACK of the head packet pulses the interrupt one cycle later. When bits 12 and 10 (DMA mode) are both set, that pulse is suppressed.
- R7: An ACK of the head packet flips the sequence bit and drops the packet. A missed ACK does not flip it while bit 11 is clear. Writing 1 to bit 6 forces DATA0, and bit 6 reads back 0.
- R8: Each write of 1 to bit 3 drops the head committed packet, so two writes empty a full double buffer. When no packet is committed, the write discards a partly loaded packet. A flush leaves the sequence bit alone.
- R9: After MAX_TRIES missed ACKs in a row, bit 5 (error) sets and the interrupt pulses, whatever the DMA mode. Writing 1 to bit 5 clears it. The packet stays queued.
- R10: Each read request returns the next byte of the head packet one cycle later, in load order. A rewind request restarts at byte 0.
- R11: While control/status bit 13 is clear, the load port is ignored.
- R12: A max-packet write of 0 or of more than MAX_PKT stores MAX_PKT. Any other value is stored as written.
- R13: With bit 11 set, the sequence bit flips on every attempt outcome, missed ACK included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control/status, 1 max packet, 2 buffer config |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Registered read data for reg_addr |
| ld_valid | input | 1 | Byte load strobe |
| ld_data | input | DATA_W | Byte to load |
| eng_start | input | 1 | Rewind to byte 0 of the head packet |
| eng_rd | input | 1 | Read next byte of the head packet |
| eng_ack | input | 1 | Host acknowledged the head packet |
| eng_noack | input | 1 | Send attempt ended without ACK |
| eng_pkt_valid | output | 1 | A committed packet is waiting |
| eng_pkt_len | output | LEN_W | Byte length of the head packet |
| eng_pid | output | 1 | Sequence bit for the head packet (0 = DATA0) |
| eng_rdata | output | DATA_W | Byte returned one cycle after eng_rd |
| dma_req | output | 1 | Request for another packet |
| ep_irq | output | 1 | One-cycle endpoint interrupt pulse |

## Verification
The bench drives a set of packet lengths through auto-commit and explicit commit. The set includes an empty packet, a one-byte maximum and out-of-range max-packet writes. A design with an off-by-one commit threshold would report the wrong length, or would hold a full packet back.

Directed cases target the following behaviour:
- Single-buffer blocking: a design that wrongly accepts a second packet lets stray bytes reach the engine.
- Flush ordering: a flush that drops the newest packet returns the wrong first byte.
- Partial-packet discard.
- DMA-request deassertion when both slots fill.
- Interrupt suppression in DMA mode.
- The retry limit: an error that is gated by DMA mode stays silent.
- Forced toggling, and the toggle-clear write.

// File: rtl/bulk_tx_pkg.sv
package bulk_tx_pkg;

  // Control/status bit positions
  localparam int CSR_PKTRDY  = 0;
  localparam int CSR_NEMPTY  = 1;
  localparam int CSR_FLUSH   = 3;
  localparam int CSR_ERR     = 5;
  localparam int CSR_CLRTOG  = 6;
  localparam int CSR_DMAMODE = 10;
  localparam int CSR_FRCTOG  = 11;
  localparam int CSR_DMAEN   = 12;
  localparam int CSR_MODE    = 13;
  localparam int CSR_ISO     = 14;
  localparam int BUF_DUAL    = 4;

  typedef enum logic [1:0] {
    SEL_CSR  = 2'd0,
    SEL_MAXP = 2'd1,
    SEL_BUF  = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic iso;
    logic mode;
    logic dmaen;
    logic frctog;
    logic dmamode;
    logic err;
  } ctl_t;

endpackage

// File: rtl/txep_pkt_store.sv
module txep_pkt_store #(
  parameter int DATA_W  = 8,
  parameter int MAX_PKT = 64,
  localparam int LEN_W  = $clog2(MAX_PKT + 1),
  localparam int OFF_W  = $clog2(MAX_PKT),
  localparam int DEPTH  = 2 * MAX_PKT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_two,
  input  logic              ld_we,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              commit,
  input  logic [LEN_W-1:0]  commit_len,
  input  logic              deq,
  input  logic              drop_fill,
  input  logic              rd_start,
  input  logic              rd_en,
  output logic [1:0]        cnt,
  output logic [LEN_W-1:0]  fill,
  output logic [LEN_W-1:0]  head_len,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              head_q;
  logic [1:0]        cnt_q;
  logic [LEN_W-1:0]  fill_q;
  logic [LEN_W-1:0]  len_q [2];
  logic [LEN_W-1:0]  rd_off_q;
  logic              wr_slot;
  logic [LEN_W-1:0]  off_sel;

  // Slot being loaded sits just behind the committed packets
  assign wr_slot = head_q ^ cnt_q[0];
  assign off_sel = rd_start ? '0 : rd_off_q;

  always_ff @(posedge clk) begin
    if (ld_we) mem[{wr_slot, fill_q[OFF_W-1:0]}] <= ld_data;
    if (rd_en) rd_data <= mem[{head_q, off_sel[OFF_W-1:0]}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q   <= 1'b0;
      cnt_q    <= 2'd0;
      fill_q   <= '0;
      len_q[0] <= '0;
      len_q[1] <= '0;
      rd_off_q <= '0;
    end else begin
      cnt_q <= cnt_q + 2'(commit) - 2'(deq);
      if (deq) head_q <= ~head_q;
      if (commit) len_q[wr_slot] <= commit_len;
      if (commit || drop_fill) fill_q <= '0;
      else if (ld_we)          fill_q <= fill_q + LEN_W'(1);
      if (deq)           rd_off_q <= '0;
      else if (rd_en)    rd_off_q <= off_sel + LEN_W'(1);
      else if (rd_start) rd_off_q <= '0;
    end
  end

  assign cnt      = cnt_q;
  assign fill     = fill_q;
  assign head_len = len_q[head_q];

  assert_count_limit_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= 2'd2);
  assert_load_has_room_R2: assert property (@(posedge clk) disable iff (rst)
    ld_we |-> (cap_two ? (cnt_q != 2'd2) : (cnt_q == 2'd0)));
  assert_len_fits_R4: assert property (@(posedge clk) disable iff (rst)
    commit |-> (commit_len <= LEN_W'(MAX_PKT)));
  assert_deq_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
    deq |-> (cnt_q != 2'd0));

endmodule

// File: rtl/txep_seq.sv
module txep_seq #(
  parameter int MAX_TRIES = 3,
  localparam int TRY_W    = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic ack,
  input  logic noack,
  input  logic force_tog,
  input  logic clr_tog,
  input  logic flush_evt,
  output logic toggle,
  output logic err_evt
);

  logic             tog_q;
  logic [TRY_W-1:0] tries_q;
  logic             ack_ok, miss, last_try;

  assign ack_ok   = ack & active;
  assign miss     = noack & active & ~ack;
  assign last_try = (tries_q == TRY_W'(MAX_TRIES - 1));
  assign err_evt  = miss & last_try;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q   <= 1'b0;
      tries_q <= '0;
    end else begin
      if (clr_tog)                         tog_q <= 1'b0;
      else if (ack_ok || (force_tog && miss)) tog_q <= ~tog_q;
      if (ack_ok || flush_evt)             tries_q <= '0;
      else if (miss)                       tries_q <= last_try ? '0 : tries_q + TRY_W'(1);
    end
  end

  assign toggle = tog_q;

  assert_tries_bound_R9: assert property (@(posedge clk) disable iff (rst)
    tries_q < TRY_W'(MAX_TRIES));
  assert_toggle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(ack || noack || clr_tog) |=> $stable(toggle));

endmodule

// File: rtl/bulk_in_ep_tx.sv
module bulk_in_ep_tx
  import bulk_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_PKT   = 64,
  parameter int MAX_TRIES = 3,
  parameter int REG_W     = 16,
  localparam int LEN_W    = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              eng_start,
  input  logic              eng_rd,
  input  logic              eng_ack,
  input  logic              eng_noack,
  output logic              eng_pkt_valid,
  output logic [LEN_W-1:0]  eng_pkt_len,
  output logic              eng_pid,
  output logic [DATA_W-1:0] eng_rdata,
  output logic              dma_req,
  output logic              ep_irq
);

  ctl_t             ctl_q, ctl_n;
  logic             dual_q, dual_n;
  logic [LEN_W-1:0] maxp_q, maxp_n;
  logic [1:0]       cnt, cnt_n;
  logic [LEN_W-1:0] fill, head_len, commit_len;
  logic             toggle, err_evt;
  logic             wr_ctl, wr_maxp, wr_buf;
  logic             has_pkt, space, space_n;
  logic             ld_we, ack_ok, flush_req, sw_commit, flush_deq, deq;
  logic             drop_fill, auto_commit, commit;
  logic [REG_W-1:0] rd_mux;

  assign wr_ctl  = reg_wr && (reg_addr == SEL_CSR);
  assign wr_maxp = reg_wr && (reg_addr == SEL_MAXP);
  assign wr_buf  = reg_wr && (reg_addr == SEL_BUF);

  assign has_pkt = (cnt != 2'd0);
  assign space   = dual_q ? (cnt != 2'd2) : (cnt == 2'd0);

  // Packet admission and removal
  assign ld_we       = ld_valid & ctl_q.mode & space;
  assign ack_ok      = eng_ack & has_pkt;
  assign flush_req   = wr_ctl & reg_wdata[CSR_FLUSH];
  assign sw_commit   = wr_ctl & reg_wdata[CSR_PKTRDY] & space;
  assign flush_deq   = flush_req & has_pkt & ~ack_ok;
  assign deq         = ack_ok | flush_deq;
  assign drop_fill   = flush_req & ~has_pkt & ~sw_commit;
  assign auto_commit = ld_we && ((fill + LEN_W'(1)) >= maxp_q);
  assign commit      = auto_commit | sw_commit;
  assign commit_len  = fill + LEN_W'(ld_we);
  assign cnt_n       = cnt + 2'(commit) - 2'(deq);

  always_comb begin
    ctl_n  = ctl_q;
    dual_n = dual_q;
    maxp_n = maxp_q;
    if (wr_ctl) begin
      ctl_n.iso     = reg_wdata[CSR_ISO];
      ctl_n.mode    = reg_wdata[CSR_MODE];
      ctl_n.dmaen   = reg_wdata[CSR_DMAEN];
      ctl_n.frctog  = reg_wdata[CSR_FRCTOG];
      ctl_n.dmamode = reg_wdata[CSR_DMAMODE];
    end
    if (err_evt)                            ctl_n.err = 1'b1;
    else if (wr_ctl && reg_wdata[CSR_ERR])  ctl_n.err = 1'b0;
    if (wr_buf) dual_n = reg_wdata[BUF_DUAL];
    if (wr_maxp) begin
      if ((reg_wdata == '0) || (reg_wdata > REG_W'(MAX_PKT))) maxp_n = LEN_W'(MAX_PKT);
      else                                                    maxp_n = reg_wdata[LEN_W-1:0];
    end
  end

  assign space_n = dual_n ? (cnt_n != 2'd2) : (cnt_n == 2'd0);

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      SEL_CSR: begin
        rd_mux[CSR_ISO]     = ctl_q.iso;
        rd_mux[CSR_MODE]    = ctl_q.mode;
        rd_mux[CSR_DMAEN]   = ctl_q.dmaen;
        rd_mux[CSR_FRCTOG]  = ctl_q.frctog;
        rd_mux[CSR_DMAMODE] = ctl_q.dmamode;
        rd_mux[CSR_ERR]     = ctl_q.err;
        rd_mux[CSR_NEMPTY]  = has_pkt;
        rd_mux[CSR_PKTRDY]  = ~space;
      end
      SEL_MAXP: rd_mux[LEN_W-1:0] = maxp_q;
      SEL_BUF:  rd_mux[BUF_DUAL]  = dual_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      dual_q    <= 1'b0;
      maxp_q    <= LEN_W'(MAX_PKT);
      dma_req   <= 1'b0;
      ep_irq    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      ctl_q     <= ctl_n;
      dual_q    <= dual_n;
      maxp_q    <= maxp_n;
      dma_req   <= ctl_n.dmaen & ctl_n.mode & space_n;
      ep_irq    <= (ack_ok & ~(ctl_q.dmaen & ctl_q.dmamode)) | err_evt;
      reg_rdata <= rd_mux;
    end
  end

  txep_pkt_store #(.DATA_W(DATA_W), .MAX_PKT(MAX_PKT)) i_store (
    .clk(clk), .rst(rst), .cap_two(dual_q),
    .ld_we(ld_we), .ld_data(ld_data),
    .commit(commit), .commit_len(commit_len),
    .deq(deq), .drop_fill(drop_fill),
    .rd_start(eng_start), .rd_en(eng_rd),
    .cnt(cnt), .fill(fill), .head_len(head_len), .rd_data(eng_rdata)
  );

  txep_seq #(.MAX_TRIES(MAX_TRIES)) i_seq (
    .clk(clk), .rst(rst), .active(has_pkt),
    .ack(eng_ack), .noack(eng_noack),
    .force_tog(ctl_q.frctog),
    .clr_tog(wr_ctl & reg_wdata[CSR_CLRTOG]),
    .flush_evt(flush_deq),
    .toggle(toggle), .err_evt(err_evt)
  );

  assign eng_pkt_valid = has_pkt;
  assign eng_pkt_len   = head_len;
  assign eng_pid       = toggle;

  assert_dma_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (ctl_q.dmaen && ctl_q.mode));
  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
    ep_irq |-> ($past(err_evt) || !($past(ctl_q.dmaen) && $past(ctl_q.dmamode))));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.err && !(wr_ctl && reg_wdata[CSR_ERR])) |=> ctl_q.err);

endmodule

// File: tb/test_bulk_in_ep_tx.sv
module test_bulk_in_ep_tx;

  localparam int LEN_W = 7;
  localparam logic [15:0] MODE = 16'h2000, DMAEN = 16'h1000, FRC = 16'h0800,
                          DMAM = 16'h0400, PRDY = 16'h0001, FLUSH = 16'h0008,
                          ERRB = 16'h0020, CLRT = 16'h0040;

  // {maxp write, bytes loaded, explicit commit, expect committed, expected length}
  localparam logic [39:0] VEC [8] = '{
    {16'd8,   8'd8, 4'd0, 4'd1, 8'd8},
    {16'd8,   8'd3, 4'd1, 4'd1, 8'd3},
    {16'd8,   8'd5, 4'd0, 4'd0, 8'd0},
    {16'd8,   8'd2, 4'd1, 4'd1, 8'd2},
    {16'd0,   8'd5, 4'd1, 4'd1, 8'd5},
    {16'd100, 8'd6, 4'd1, 4'd1, 8'd6},
    {16'd1,   8'd1, 4'd0, 4'd1, 8'd1},
    {16'd4,   8'd0, 4'd1, 4'd1, 8'd0}
  };

  logic clk = 0, rst = 1;
  logic reg_wr = 0, ld_valid = 0, eng_start = 0, eng_rd = 0, eng_ack = 0, eng_noack = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [7:0] ld_data = 0, eng_rdata;
  logic eng_pkt_valid, eng_pid, dma_req, ep_irq;
  logic [LEN_W-1:0] eng_pkt_len;

  int n_chk = 0, n_fail = 0;
  logic exp_tog = 0;
  logic [15:0] r;
  logic [7:0] b;

  always #4 clk = ~clk;

  bulk_in_ep_tx i_bulk_in_ep_tx (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
    .eng_start(eng_start), .eng_rd(eng_rd), .eng_ack(eng_ack), .eng_noack(eng_noack),
    .eng_pkt_valid(eng_pkt_valid), .eng_pkt_len(eng_pkt_len), .eng_pid(eng_pid),
    .eng_rdata(eng_rdata), .dma_req(dma_req), .ep_irq(ep_irq)
  );

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick; reg_wr = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a; tick; v = reg_rdata;
  endtask

  task automatic load(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      ld_valid = 1; ld_data = base + 8'(i); tick;
    end
    ld_valid = 0;
  endtask

  task automatic rdb(input logic st, output logic [7:0] v);
    eng_rd = 1; eng_start = st; tick; eng_rd = 0; eng_start = 0; v = eng_rdata;
  endtask

  task automatic ack_pkt(input string req, input logic exp_irq);
    eng_ack = 1; tick; eng_ack = 0;
    exp_tog = ~exp_tog;
    chk({req, " irq"}, 32'(ep_irq), 32'(exp_irq));
    chk("R7 toggle after ack", 32'(eng_pid), 32'(exp_tog));
  endtask

  task automatic miss_once; eng_noack = 1; tick; eng_noack = 0; endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst = 0;
    // R1 reset state
    chk("R1 dma_req", 32'(dma_req), 0);
    chk("R1 irq", 32'(ep_irq), 0);
    chk("R1 valid", 32'(eng_pkt_valid), 0);
    chk("R1 pid", 32'(eng_pid), 0);
    rreg(0, r); chk("R1 csr", 32'(r), 0);
    rreg(1, r); chk("R1 maxp", 32'(r), 64);
    rreg(2, r); chk("R1 bufcfg", 32'(r), 0);

    wreg(0, MODE);
    // Vector table: commit rules, lengths, data order (R4, R10, R12, R8)
    for (int k = 0; k < 8; k++) begin
      logic [7:0] base, el;
      base = 8'(k * 16);
      el = VEC[k][7:0];
      wreg(1, VEC[k][39:24]);
      load(int'(VEC[k][23:16]), base);
      if (VEC[k][15:12] != 0) wreg(0, MODE | PRDY);
      chk("R4 commit", 32'(eng_pkt_valid), 32'(VEC[k][11:8] != 0));
      if (VEC[k][11:8] != 0) begin
        chk("R4 R12 length", 32'(eng_pkt_len), 32'(el));
        for (int i = 0; i < int'(el); i++) begin
          rdb(i == 0, b);
          chk("R10 byte order", 32'(b), 32'(base + 8'(i)));
        end
        ack_pkt("R6 ack", 1);
        chk("R7 drained", 32'(eng_pkt_valid), 0);
      end else begin
        wreg(0, MODE | FLUSH); // R8 discard partial
      end
    end

    // R2 single buffer (maxp is 4)
    load(4, 8'hA0);
    rreg(0, r);
    chk("R2 full flag", 32'(r[0]), 1);
    chk("R4 nonempty flag", 32'(r[1]), 1);
    load(4, 8'hB0);
    ack_pkt("R6 ack", 1);
    chk("R2 extra bytes ignored", 32'(eng_pkt_valid), 0);
    rreg(0, r); chk("R2 empty after ack", 32'(r[1:0]), 0);

    // R3 double buffer
    wreg(2, 16'h0010);
    rreg(2, r); chk("R3 bufcfg", 32'(r), 16);
    load(4, 8'hC0); load(4, 8'hD0);
    rreg(0, r); chk("R3 full with two", 32'(r[0]), 1);
    rdb(1, b); chk("R3 first packet", 32'(b), 8'hC0);
    ack_pkt("R6 ack", 1);
    chk("R3 second waits", 32'(eng_pkt_valid), 1);
    rdb(1, b); chk("R3 second packet", 32'(b), 8'hD0);
    ack_pkt("R6 ack", 1);
    chk("R3 drained", 32'(eng_pkt_valid), 0);

    // R5 DMA request, R8 two flushes
    wreg(0, DMAEN); chk("R5 no req without mode", 32'(dma_req), 0);
    wreg(0, MODE | DMAEN); chk("R5 req when free", 32'(dma_req), 1);
    load(4, 8'hE0); chk("R5 one slot free", 32'(dma_req), 1);
    load(4, 8'hF0); chk("R5 both slots used", 32'(dma_req), 0);
    wreg(0, MODE | DMAEN | FLUSH);
    chk("R5 req after flush", 32'(dma_req), 1);
    chk("R8 one flushed", 32'(eng_pkt_valid), 1);
    rdb(1, b); chk("R8 head dropped first", 32'(b), 8'hF0);
    wreg(0, MODE | DMAEN | FLUSH);
    chk("R8 second flush empties", 32'(eng_pkt_valid), 0);
    chk("R8 toggle untouched", 32'(eng_pid), 32'(exp_tog));

    // R6 suppression in DMA mode
    wreg(0, MODE | DMAEN | DMAM);
    load(4, 8'h11); ack_pkt("R6 suppressed", 0);
    wreg(0, MODE | DMAEN);
    load(4, 8'h22); ack_pkt("R6 not suppressed", 1);

    // R9 retry limit
    wreg(0, MODE | DMAEN | DMAM);
    load(4, 8'h33);
    miss_once; chk("R9 miss 1 no irq", 32'(ep_irq), 0);
    miss_once; chk("R9 miss 2 no irq", 32'(ep_irq), 0);
    miss_once; chk("R9 limit irq", 32'(ep_irq), 1);
    chk("R7 miss keeps toggle", 32'(eng_pid), 32'(exp_tog));
    rreg(0, r); chk("R9 error set", 32'(r[5]), 1);
    chk("R9 packet kept", 32'(eng_pkt_valid), 1);
    wreg(0, MODE | DMAEN | DMAM | ERRB);
    rreg(0, r); chk("R9 error cleared", 32'(r[5]), 0);
    ack_pkt("R6 suppressed", 0);

    // R13 forced toggle
    wreg(0, MODE | FRC);
    load(4, 8'h44);
    miss_once; exp_tog = ~exp_tog;
    chk("R13 flip on miss", 32'(eng_pid), 32'(exp_tog));
    ack_pkt("R13 ack", 1);
    wreg(0, MODE);

    // R7 clear toggle
    if (!exp_tog) begin load(4, 8'h55); ack_pkt("R7 ack", 1); end
    chk("R7 at DATA1", 32'(eng_pid), 1);
    wreg(0, MODE | CLRT); exp_tog = 0;
    chk("R7 cleared", 32'(eng_pid), 0);
    rreg(0, r); chk("R7 clear bit reads 0", 32'(r[6]), 0);

    // R11 loads ignored while mode clear
    wreg(0, 16'h0000);
    load(4, 8'h66);
    chk("R11 no commit", 32'(eng_pkt_valid), 0);
    wreg(0, MODE | PRDY);
    chk("R11 empty packet", 32'(eng_pkt_valid), 1);
    chk("R11 bytes not stored", 32'(eng_pkt_len), 0);
    ack_pkt("R6 ack", 1);

    // R12 max packet clamp
    wreg(1, 16'd100); rreg(1, r); chk("R12 clamp high", 32'(r), 64);
    wreg(1, 16'd9);   rreg(1, r); chk("R12 in range", 32'(r), 9);
    wreg(1, 16'd0);   rreg(1, r); chk("R12 clamp zero", 32'(r), 64);

    // R10 rewind
    load(3, 8'h70); wreg(0, MODE | PRDY);
    rdb(1, b); chk("R10 byte0", 32'(b), 8'h70);
    rdb(0, b); chk("R10 byte1", 32'(b), 8'h71);
    rdb(1, b); chk("R10 rewind", 32'(b), 8'h70);
    rdb(0, b); chk("R10 after rewind", 32'(b), 8'h71);
    ack_pkt("R6 ack", 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule